// File: doc/BRIEF.md
# Compare-and-Jump Condition Unit

This block decides whether a compare-and-jump instruction is taken. It receives a 4-bit condition code and a 32-bit first operand. The second operand is either a 32-bit register value or a 16-bit immediate; a format select picks which one. The immediate is sign-extended to 32 bits before the compare. The block returns a take-jump flag and a flag that marks a condition code with no defined meaning.

The condition codes are sparse. Code 0 always jumps. Codes 1 and 2 test inequality and equality. Codes 3 and 4 are unsigned greater-than and greater-or-equal. Codes 0xC and 0xD are the signed versions of the same two compares. Every other code never jumps and raises the invalid flag.

Both outputs are registered. The result for the inputs presented before a rising clock edge appears just after that edge. Computing the jump target and updating the instruction pointer belong to the surrounding pipeline.

Top module: `jump_cond_unit`

## Requirements
- R1: Condition code 0x0 sets `take_jump` to 1 whatever the operand values are.
- R2: Condition code 0x1 sets `take_jump` to 1 exactly when the first operand differs from the second operand.
- R3: Condition code 0x2 sets `take_jump` to 1 exactly when the first operand equals the second operand.
- R4: Condition code 0x3 takes the jump when first > second, and code 0x4 takes it when first >= second, both compared as unsigned 32-bit values.
- R5: Condition code 0xC takes the jump when first > second, and code 0xD takes it when first >= second, both compared as two's-complement signed 32-bit values.
- R6: When `use_imm` is 1, the second operand is `imm` sign-extended from bit 15 to 32 bits, and `op_b` has no effect on the result. When `use_imm` is 0, the second operand is `op_b`.
- R7: Codes 0x5 to 0xB, 0xE and 0xF give `take_jump` = 0 and `cond_bad` = 1. Codes 0x0 to 0x4, 0xC and 0xD give `cond_bad` = 0.
- R8: Both outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high at a rising edge, both outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond | input | 4 | Jump condition code |
| op_a | input | 32 | First operand (register value) |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate second operand, sign-extended |
| use_imm | input | 1 | 1 selects the immediate, 0 selects `op_b` |
| take_jump | output | 1 | Registered: jump is taken |
| cond_bad | output | 1 | Registered: condition code is undefined |

## Verification
The block keeps no state beyond the two output flops. A faulty decode, compare or operand select therefore shows on `take_jump` or `cond_bad` one cycle after the offending inputs, and never later.

The operand pairs are chosen so that the unsigned and signed orderings disagree (top bit set on one side only). They also include equal values, so that a swapped signed/unsigned path or an off-by-one between > and >= changes the output. Immediates with bit 15 set, paired with a `op_b` that would give the opposite answer, expose a missing sign extension or a wrong select in that same cycle.

// File: rtl/jump_cond_pkg.sv
package jump_cond_pkg;
  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    JC_ALWAYS = 4'h0,
    JC_NE     = 4'h1,
    JC_EQ     = 4'h2,
    JC_GTU    = 4'h3,
    JC_GEU    = 4'h4,
    JC_GTS    = 4'hC,
    JC_GES    = 4'hD
  } jcond_e;

  typedef struct packed {
    logic eq;
    logic gtu;
    logic geu;
    logic gts;
    logic ges;
  } cmp_flags_t;
endpackage

// File: rtl/jc_operand_sel.sv
module jc_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              pick_imm,
  output logic [DATA_W-1:0] operand
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_noext
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  assign operand = pick_imm ? imm_ext : reg_val;
endmodule

// File: rtl/jc_compare.sv
module jc_compare
  import jump_cond_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output cmp_flags_t        flags
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] diff;
  logic            borrow;
  logic            same;
  logic            lt_s;

  assign diff   = {1'b0, lhs} - {1'b0, rhs};
  assign borrow = diff[DATA_W];
  assign same   = (lhs == rhs);
  assign lt_s   = (lhs[MSB] ^ rhs[MSB]) ? lhs[MSB] : borrow;

  always_comb begin
    flags.eq  = same;
    flags.geu = ~borrow;
    flags.gtu = ~borrow & ~same;
    flags.ges = ~lt_s;
    flags.gts = ~lt_s & ~same;
  end
endmodule

// File: rtl/jc_cond_decode.sv
module jc_cond_decode
  import jump_cond_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  cmp_flags_t        flags,
  output logic              take,
  output logic              bad
);
  always_comb begin
    take = 1'b0;
    bad  = 1'b0;
    case (code)
      JC_ALWAYS: take = 1'b1;
      JC_NE:     take = ~flags.eq;
      JC_EQ:     take = flags.eq;
      JC_GTU:    take = flags.gtu;
      JC_GEU:    take = flags.geu;
      JC_GTS:    take = flags.gts;
      JC_GES:    take = flags.ges;
      default:   bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/jump_cond_unit.sv
module jump_cond_unit
  import jump_cond_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cond,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic              take_jump,
  output logic              cond_bad
);
  logic [DATA_W-1:0] rhs;
  cmp_flags_t        flags;
  logic              take_d;
  logic              bad_d;

  jc_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .reg_val (op_b),
    .imm_val (imm),
    .pick_imm(use_imm),
    .operand (rhs)
  );

  jc_compare #(.DATA_W(DATA_W)) u_cmp (
    .lhs  (op_a),
    .rhs  (rhs),
    .flags(flags)
  );

  jc_cond_decode u_dec (
    .code (cond),
    .flags(flags),
    .take (take_d),
    .bad  (bad_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_jump <= 1'b0;
      cond_bad  <= 1'b0;
    end else begin
      take_jump <= take_d;
      cond_bad  <= bad_d;
    end
  end
endmodule

// File: rtl/jump_cond_unit_chk.sv
module jump_cond_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cond,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [IMM_W-1:0]  imm,
  input logic              use_imm,
  input logic              take_jump,
  input logic              cond_bad
);
  logic known_code;
  assign known_code = (cond <= 4'h4) || (cond == 4'hC) || (cond == 4'hD);

  // R8
  reset_clears_chk: assert property (@(posedge clk) rst |=> (!take_jump && !cond_bad));

  // R1
  always_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'h0) |=> take_jump);

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    !known_code |=> (cond_bad && !take_jump));

  // R7
  good_code_chk: assert property (@(posedge clk) disable iff (rst)
    known_code |=> !cond_bad);

  // R3
  reg_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'h2 && !use_imm) |=> (take_jump == $past(op_a == op_b)));

  // R2
  reg_differ_chk: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'h1 && !use_imm) |=> (take_jump == $past(op_a != op_b)));
endmodule

bind jump_cond_unit jump_cond_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cond     (cond),
  .op_a     (op_a),
  .op_b     (op_b),
  .imm      (imm),
  .use_imm  (use_imm),
  .take_jump(take_jump),
  .cond_bad (cond_bad)
);

// File: tb/jump_cond_unit_bench.sv
module jump_cond_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond = 4'h0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic        take_jump;
  logic        cond_bad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic  exp_take_q[$];
  logic  exp_bad_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  jump_cond_unit u_jump_cond_unit (
    .clk(clk), .rst(rst), .cond(cond), .op_a(op_a), .op_b(op_b),
    .imm(imm), .use_imm(use_imm), .take_jump(take_jump), .cond_bad(cond_bad)
  );

  task automatic drive(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic ui, input string tag);
    logic [31:0] rhs;
    logic        t;
    logic        bd;
    @(negedge clk);
    cond = c; op_a = a; op_b = b; imm = im; use_imm = ui;
    rhs = ui ? {{16{im[15]}}, im} : b;
    t = 1'b0; bd = 1'b0;
    case (c)
      4'h0: t = 1'b1;
      4'h1: t = (a != rhs);
      4'h2: t = (a == rhs);
      4'h3: t = (a > rhs);
      4'h4: t = (a >= rhs);
      4'hC: t = ($signed(a) > $signed(rhs));
      4'hD: t = ($signed(a) >= $signed(rhs));
      default: bd = 1'b1;
    endcase
    exp_take_q.push_back(t);
    exp_bad_q.push_back(bd);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_take_q.size() > 0) begin
        logic  et;
        logic  eb;
        string tg;
        et = exp_take_q.pop_front();
        eb = exp_bad_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (take_jump !== et || cond_bad !== eb) begin
          errors++;
          $display("FAIL %s: take=%b bad=%b expected take=%b bad=%b",
                   tg, take_jump, cond_bad, et, eb);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (take_jump !== 1'b0 || cond_bad !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: take=%b bad=%b expected 0 0", take_jump, cond_bad);
    end
    @(negedge clk);
    rst = 1'b0;

    drive(4'h0, 32'h0, 32'h0, 16'h0, 1'b0, "R1 always equal ops");
    drive(4'h0, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, "R1 always differing ops");
    drive(4'h0, 32'h5, 32'h0, 16'h1234, 1'b1, "R1 always imm form");
    drive(4'h1, 32'h10, 32'h10, 16'h0, 1'b0, "R2 ne equal");
    drive(4'h1, 32'h10, 32'h11, 16'h0, 1'b0, "R2 ne differ");
    drive(4'h2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 1'b0, "R3 eq equal");
    drive(4'h2, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 16'h0, 1'b0, "R3 eq differ");
    drive(4'h3, 32'h8000_0000, 32'h1, 16'h0, 1'b0, "R4 gtu top bit");
    drive(4'h3, 32'h7, 32'h7, 16'h0, 1'b0, "R4 gtu equal");
    drive(4'h3, 32'h6, 32'h7, 16'h0, 1'b0, "R4 gtu less");
    drive(4'h4, 32'h7, 32'h7, 16'h0, 1'b0, "R4 geu equal");
    drive(4'h4, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, "R4 geu less");
    drive(4'hC, 32'h8000_0000, 32'h1, 16'h0, 1'b0, "R5 gts negative lhs");
    drive(4'hC, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, "R5 gts over minus one");
    drive(4'hC, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'h0, 1'b0, "R5 gts equal");
    drive(4'hD, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'h0, 1'b0, "R5 ges equal");
    drive(4'hD, 32'hFFFF_FFF0, 32'hFFFF_FFF1, 16'h0, 1'b0, "R5 ges less");
    drive(4'h2, 32'hFFFF_FFFF, 32'h0000_FFFF, 16'hFFFF, 1'b1, "R6 imm sign-ext eq");
    drive(4'h2, 32'h0000_FFFF, 32'h0000_FFFF, 16'hFFFF, 1'b1, "R6 imm not zero-ext");
    drive(4'hC, 32'h0, 32'hFFFF_0000, 16'h8000, 1'b1, "R6 imm negative gts");
    drive(4'h3, 32'h0, 32'h0, 16'h8000, 1'b1, "R6 imm large unsigned");
    drive(4'h4, 32'h0000_1234, 32'hFFFF_FFFF, 16'h1234, 1'b1, "R6 imm ignores op_b");
    for (int k = 5; k <= 15; k++) begin
      if (k != 12 && k != 13)
        drive(4'(k), 32'h3, 32'h3, 16'h3, 1'b0, $sformatf("R7 undefined code %0h", k));
    end
    drive(4'hF, 32'h9, 32'h2, 16'h0, 1'b0, "R7 undefined code F differ");
    drive(4'h4, 32'h9, 32'h2, 16'h0, 1'b0, "R7 valid code clears bad");

    drive(4'h0, 32'h0, 32'h0, 16'h0, 1'b0, "R8 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (take_jump !== 1'b0 || cond_bad !== 1'b0) begin
      errors++;
      $display("FAIL R8 mid-run reset: take=%b bad=%b expected 0 0", take_jump, cond_bad);
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule